// File: doc/BRIEF.md
# Periodic Micro-Frame Index Counter

This block holds the frame index of a host controller's periodic scheduler. While the controller runs, an external strobe marks the start of each 125 µs micro-frame, and the block advances a 14-bit count once per strobe. The three low bits of the count number the micro-frames inside a frame. The bits above them select an entry in the periodic frame list. The list can hold 1024, 512 or 256 entries, so the width of the index field depends on the configured size.

When the index field wraps back to zero, a status flag is set and stays set until software clears it by writing a one. Software can load the counter through a 32-bit register port, but only with a full-width write made while the controller is stopped. A loaded value also becomes the current start-of-frame number seen by the rest of the controller. All other writes to the counter are dropped.

Top module: `uframe_index`

## Requirements
- R1: After reset the count, the start-of-frame number, the list index and the rollover flag are all zero.
- R2: While `run_i` is high, each cycle with `uf_tick_i` high adds one to the 14-bit count, which wraps from 16383 to 0. While `run_i` is low, ticks have no effect and the count holds.
- R3: `list_idx_o` shows count bits [12:3] when `list_size_i` is 00 or 11, count bits [11:3] when it is 01, and count bits [10:3] when it is 10. The unused upper index bits are zero.
- R4: On an advancing tick where all count bits up to the top index bit for the current size are one, the index field wraps to zero and `rollover_o` is set in the next cycle.
- R5: The rollover flag reads at address 1, bit 0. It stays set until a write to address 1 with `reg_be_i[0]` high and `reg_wdata_i[0]` equal to 1. Writing 0 to that bit leaves the flag unchanged.
- R6: If a rollover and a clearing write occur in the same cycle, the flag ends up set.
- R7: A write to address 0 with `reg_be_i` equal to 1111 while `run_i` is low loads `reg_wdata_i[13:0]` into the count. `sof_num_o` shows the loaded value in the next cycle.
- R8: A write to address 0 with any byte enable low is ignored, and the count keeps its value.
- R9: A write to address 0 while `run_i` is high is ignored.
- R10: A read of address 0 returns the count in bits [13:0] with zeros above it. A read of address 1 returns zeros in bits [31:1]. Writes to reserved bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Controller run (1) / stop (0) |
| list_size_i | input | 2 | Frame-list size select: 00/11 = 1024, 01 = 512, 10 = 256 |
| uf_tick_i | input | 1 | One-cycle strobe at each micro-frame start |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 = counter, 1 = status |
| reg_be_i | input | 4 | Byte enables of the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| list_idx_o | output | 10 | Frame-list entry index |
| sof_num_o | output | 14 | Current start-of-frame number (the count) |
| rollover_o | output | 1 | Sticky frame-list rollover flag |

## Verification
Two events can fall in the same cycle: a micro-frame tick that wraps the index, which sets the flag, and a software write-one that clears the same flag. The bench loads the count so that it sits one step before the wrap point for the 256-entry size. It then raises the tick and the clearing write on the same clock edge while the controller runs. On the following cycle it expects the flag to read as set and the count to show the wrapped value. A separate clear with no tick then has to drop the flag, which shows that the earlier result came from the priority rule and not from a clear that had no effect.

// File: rtl/uframe_pkg.sv
// Shared constants, the frame-list size encoding and helpers for the
// micro-frame index counter.
package uframe_pkg;
    localparam int CNT_W     = 14;  // width of the index counter
    localparam int UF_BITS   = 3;   // micro-frame bits below the list index
    localparam int IDX_MAX_W = 10;  // index width for the largest list
    localparam int DATA_W    = 32;  // register port width
    localparam int BE_W      = DATA_W / 8;
    localparam int N_SIZES   = 4;   // number of size select codes

    typedef enum logic [1:0] {
        LS_1024 = 2'b00,
        LS_512  = 2'b01,
        LS_256  = 2'b10,
        LS_ALT  = 2'b11   // treated as 1024 entries
    } list_size_e;

    // Number of index bits dropped for a given size code.
    function automatic int size_shrink(input int code);
        return (code == 1) ? 1 : (code == 2) ? 2 : 0;
    endfunction
endpackage

// File: rtl/uframe_wr_decode.sv
// Write qualifier: turns a raw register write into a counter-load strobe
// and a status-clear strobe.
// Assumes: the counter is loaded only by full-width writes while stopped.
module uframe_wr_decode #(
    parameter int BE_W = 4
) (
    input  logic            run_i,
    input  logic            wr_i,
    input  logic            addr_i,
    input  logic [BE_W-1:0] be_i,
    input  logic            clr_bit_i,
    output logic            cnt_load_o,
    output logic            flag_clr_o
);
    // Decide which write, if any, is allowed to take effect.
    always_comb begin
        cnt_load_o = wr_i && !addr_i && (&be_i) && !run_i;
        flag_clr_o = wr_i && addr_i && be_i[0] && clr_bit_i;
    end
endmodule

// File: rtl/uframe_count.sv
// Index counter: advances on qualified ticks and accepts a load. It derives
// the list index and the wrap point from the size select.
// Assumes: load and advance never coincide (load needs run low).
module uframe_count
    import uframe_pkg::*;
#(
    parameter int CW      = CNT_W,
    parameter int UB      = UF_BITS,
    parameter int IW      = IDX_MAX_W,
    parameter int NS      = N_SIZES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic [1:0]    size_i,
    output logic [CW-1:0] cnt_o,
    output logic [IW-1:0] idx_o,
    output logic          wrap_o
);
    logic [CW-1:0] cnt_q;
    logic [NS-1:0] wrap_cand;
    logic [IW-1:0] idx_cand [NS];

    // Count register: reset, load or advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (adv_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // One index slice and one wrap detector for each size code.
    for (genvar s = 0; s < NS; s++) begin : g_size
        localparam int TOP = UB + IW - size_shrink(s);
        assign idx_cand[s]  = IW'(cnt_q[TOP-1:UB]);
        assign wrap_cand[s] = &cnt_q[TOP-1:0];
    end

    // Pick the slice that matches the current size select.
    always_comb begin
        idx_o  = idx_cand[size_i];
        wrap_o = adv_i && wrap_cand[size_i];
        cnt_o  = cnt_q;
    end
endmodule

// File: rtl/uframe_flag.sv
// Sticky rollover flag with write-one-to-clear. A set in the same cycle
// as a clear wins.
module uframe_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Hold the flag; a new set takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/uframe_index.sv
// Top of the periodic micro-frame index counter. It joins the write
// qualifier, the counter and the status flag, and muxes the read data.
// Assumes: uf_tick_i is a one-cycle strobe; reads are combinational.
module uframe_index
    import uframe_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int IW = IDX_MAX_W,
    parameter int DW = DATA_W,
    parameter int BW = BE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [1:0]    list_size_i,
    input  logic          uf_tick_i,
    input  logic          reg_wr_i,
    input  logic          reg_addr_i,
    input  logic [BW-1:0] reg_be_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic [IW-1:0] list_idx_o,
    output logic [CW-1:0] sof_num_o,
    output logic          rollover_o
);
    logic cnt_load, flag_clr, wrap_hit, adv;
    logic [CW-1:0] cnt;

    assign adv = run_i && uf_tick_i;

    uframe_wr_decode #(.BE_W(BW)) i_dec (
        .run_i      (run_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .be_i       (reg_be_i),
        .clr_bit_i  (reg_wdata_i[0]),
        .cnt_load_o (cnt_load),
        .flag_clr_o (flag_clr)
    );

    uframe_count #(.CW(CW), .IW(IW)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .load_i     (cnt_load),
        .load_val_i (reg_wdata_i[CW-1:0]),
        .size_i     (list_size_i),
        .cnt_o      (cnt),
        .idx_o      (list_idx_o),
        .wrap_o     (wrap_hit)
    );

    uframe_flag i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wrap_hit),
        .clr_i  (flag_clr),
        .flag_o (rollover_o)
    );

    // Read mux: reserved bits always return zero.
    always_comb begin
        if (reg_addr_i)
            reg_rdata_o = DW'(rollover_o);
        else
            reg_rdata_o = DW'(cnt);
    end

    assign sof_num_o = cnt;
endmodule

// File: rtl/uframe_index_chk.sv
// Checker for the micro-frame index counter, attached to the top by bind.
module uframe_index_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run_i,
    input logic [1:0]  list_size_i,
    input logic        uf_tick_i,
    input logic        reg_wr_i,
    input logic        reg_addr_i,
    input logic [3:0]  reg_be_i,
    input logic [31:0] reg_wdata_i,
    input logic [31:0] reg_rdata_o,
    input logic [9:0]  list_idx_o,
    input logic [13:0] sof_num_o,
    input logic        rollover_o
);
    logic at_wrap;
    logic [9:0] exp_idx;

    // Independent view of the wrap point and of the index slice.
    always_comb begin
        case (list_size_i)
            2'b01:   begin at_wrap = &sof_num_o[11:0]; exp_idx = {1'b0, sof_num_o[11:3]}; end
            2'b10:   begin at_wrap = &sof_num_o[10:0]; exp_idx = {2'b0, sof_num_o[10:3]}; end
            default: begin at_wrap = &sof_num_o[12:0]; exp_idx = sof_num_o[12:3]; end
        endcase
    end

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && uf_tick_i |=> sof_num_o == 14'($past(sof_num_o) + 14'd1));
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && !(reg_wr_i && !reg_addr_i) |=> $stable(sof_num_o));
    p_index_slice_r3: assert property (@(posedge clk) disable iff (!rst_n)
        list_idx_o == exp_idx);
    p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && uf_tick_i && at_wrap |=> rollover_o);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_o && !(reg_wr_i && reg_addr_i && reg_be_i[0] && reg_wdata_i[0]) |=> rollover_o);
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && uf_tick_i && at_wrap && reg_wr_i && reg_addr_i && reg_be_i[0] |=> rollover_o);
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && reg_wr_i && !reg_addr_i && reg_be_i == 4'hF |=> sof_num_o == $past(reg_wdata_i[13:0]));
    p_partial_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i && !reg_addr_i && reg_be_i != 4'hF && !(run_i && uf_tick_i) |=> $stable(sof_num_o));
    p_run_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !uf_tick_i && reg_wr_i && !reg_addr_i |=> $stable(sof_num_o));
    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i ? reg_rdata_o[31:1] == 31'd0 : reg_rdata_o[31:14] == 18'd0));
endmodule

bind uframe_index uframe_index_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .list_size_i (list_size_i),
    .uf_tick_i   (uf_tick_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_be_i    (reg_be_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .list_idx_o  (list_idx_o),
    .sof_num_o   (sof_num_o),
    .rollover_o  (rollover_o)
);

// File: tb/test_uframe_index.sv
module test_uframe_index;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic [1:0]  list_size_i = 2'b00;
    logic        uf_tick_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_addr_i = 1'b0;
    logic [3:0]  reg_be_i = 4'h0;
    logic [31:0] reg_wdata_i = 32'h0;
    logic [31:0] reg_rdata_o;
    logic [9:0]  list_idx_o;
    logic [13:0] sof_num_o;
    logic        rollover_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    uframe_index i_uframe_index (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .list_size_i(list_size_i),
        .uf_tick_i(uf_tick_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_be_i(reg_be_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .list_idx_o(list_idx_o), .sof_num_o(sof_num_o), .rollover_o(rollover_o)
    );

    typedef struct packed {
        logic [1:0]  sz;
        logic [13:0] load;
        logic [3:0]  nt;
        logic [13:0] esof;
        logic [9:0]  eidx;
        logic        ef;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 14'h0000, 4'd5, 14'h0005, 10'h000, 1'b0},
        '{2'd0, 14'h1FFE, 4'd2, 14'h2000, 10'h000, 1'b1},
        '{2'd1, 14'h0FFF, 4'd1, 14'h1000, 10'h000, 1'b1},
        '{2'd2, 14'h07F8, 4'd3, 14'h07FB, 10'h0FF, 1'b0},
        '{2'd2, 14'h07FF, 4'd1, 14'h0800, 10'h000, 1'b1},
        '{2'd0, 14'h0FFF, 4'd1, 14'h1000, 10'h200, 1'b0},
        '{2'd3, 14'h1FFF, 4'd1, 14'h2000, 10'h000, 1'b1},
        '{2'd1, 14'h3FFF, 4'd1, 14'h0000, 10'h000, 1'b1},
        '{2'd3, 14'h0A55, 4'd0, 14'h0A55, 10'h14A, 1'b0},
        '{2'd1, 14'h1A55, 4'd0, 14'h1A55, 10'h14A, 1'b0},
        '{2'd2, 14'h1A55, 4'd0, 14'h1A55, 10'h04A, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic addr, input logic [3:0] be, input logic [31:0] data);
        reg_wr_i = 1'b1; reg_addr_i = addr; reg_be_i = be; reg_wdata_i = data;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_be_i = 4'h0; reg_wdata_i = 32'h0; reg_addr_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            uf_tick_i = 1'b1;
            @(negedge clk);
            uf_tick_i = 1'b0;
        end
    endtask

    task automatic read_reg(input logic addr, output logic [31:0] val);
        reg_addr_i = addr;
        #1;
        val = reg_rdata_o;
        reg_addr_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sof", 32'(sof_num_o), 32'h0);
        check("R1 idx", 32'(list_idx_o), 32'h0);
        check("R1 flag", 32'(rollover_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: load while stopped, clear flag, run N ticks, stop, compare.
        for (int v = 0; v < NV; v++) begin
            run_i = 1'b0;
            list_size_i = VECS[v].sz;
            reg_write(1'b0, 4'hF, 32'(VECS[v].load));
            reg_write(1'b1, 4'hF, 32'h1);
            run_i = 1'b1;
            ticks(int'(VECS[v].nt));
            run_i = 1'b0;
            check("R2/R7 sof", 32'(sof_num_o), 32'(VECS[v].esof));
            check("R3 idx", 32'(list_idx_o), 32'(VECS[v].eidx));
            check("R4 flag", 32'(rollover_o), 32'(VECS[v].ef));
        end

        // R2: ticks while stopped do nothing
        list_size_i = 2'b00;
        reg_write(1'b0, 4'hF, 32'h0123);
        ticks(3);
        check("R2 hold", 32'(sof_num_o), 32'h0123);

        // R8: partial write ignored
        reg_write(1'b0, 4'b0011, 32'h0000_0456);
        check("R8 partial", 32'(sof_num_o), 32'h0123);
        reg_write(1'b0, 4'b1110, 32'h0000_0789);
        check("R8 partial2", 32'(sof_num_o), 32'h0123);

        // R9: write while running ignored
        run_i = 1'b1;
        reg_write(1'b0, 4'hF, 32'h0000_0999);
        check("R9 run write", 32'(sof_num_o), 32'h0123);
        run_i = 1'b0;

        // R10: reserved bits read zero, upper write data dropped
        reg_write(1'b0, 4'hF, 32'hFFFF_C0AB);
        read_reg(1'b0, rd);
        check("R10 cnt read", rd, 32'h0000_00AB);

        // R5: write 0 leaves flag, write 1 clears
        reg_write(1'b0, 4'hF, 32'h07FF);
        list_size_i = 2'b10;
        run_i = 1'b1;
        ticks(1);
        run_i = 1'b0;
        reg_write(1'b1, 4'hF, 32'hFFFF_FFFE);
        read_reg(1'b1, rd);
        check("R5 write0 keeps / R10 status read", rd, 32'h1);
        reg_write(1'b1, 4'h1, 32'h1);
        check("R5 clear", 32'(rollover_o), 32'h0);

        // R6: rollover and clear in the same cycle -> set wins
        reg_write(1'b0, 4'hF, 32'h07FF);
        reg_write(1'b1, 4'hF, 32'h1);
        run_i = 1'b1;
        uf_tick_i = 1'b1;
        reg_write(1'b1, 4'h1, 32'h1);
        uf_tick_i = 1'b0;
        run_i = 1'b0;
        check("R6 set wins", 32'(rollover_o), 32'h1);
        check("R6 sof", 32'(sof_num_o), 32'h0800);
        reg_write(1'b1, 4'h1, 32'h1);
        check("R6 later clear", 32'(rollover_o), 32'h0);

        // R1: reset re-applied mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", 32'(sof_num_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule